// File: doc/BRIEF.md
# Sampling Converter Serial Output Engine

This block models the digital side of a successive-approximation converter that hands its results out over a serial port. Two active-low controls, a chip select and a read/convert line, are combined by OR. The moment both are low, a conversion begins. A busy flag stays low for a fixed number of system clock cycles. When busy returns high, the parallel result supplied by the analog core stand-in is captured into the result register.

A mode pin chooses how the result leaves the block. In internal mode, the block produces its own data clock during each conversion and shifts out the previous result. In external mode, a host toggles an external data clock while the chip select is low and the read/convert line is high. Read during a conversion, this gives the previous result. Read once busy is high again, it gives the new result. An optional sync bit can lead the word. It is armed by a data clock transition made while the chip select is high, or while both controls are low. All inputs are sampled on the system clock. Until the first conversion completes, the result register holds a flagged power-up word.

Top module: `sar_serial_port`

## Requirements
- R1: After reset, busy is 1 and the data clock output, the serial data line and the sync output are all 0.
- R2: A conversion starts on the clock edge at which (cs_n OR rc_n) is sampled 0, having been 1 at the edge before, while busy is 1. Either control may fall last. Busy is then low for exactly CONV_CYCLES cycles.
- R3: A start condition that appears while busy is low is ignored and does not lengthen or restart the conversion.
- R4: The result register loads core_result only on the edge at which busy returns to 1. Before the first conversion completes it holds PWRUP_WORD (16'hA5C3 by default).
- R5: With ext_mode = 0, a conversion start emits the result register (the previous result) MSB first. Each bit is held for 2 cycles, with the data clock low in the first cycle and high in the second, for exactly 16 pulses. Afterwards the data clock and the data line stay 0.
- R6: With ext_mode = 1 and no sync armed, the k-th rising edge of xclk that is sampled while cs_n = 0 and rc_n = 1 drives bit 16-k of the word (k = 1 gives the MSB, bit 15). From the 17th such edge on, the data line is 0.
- R7: An xclk transition sampled while cs_n = 1, or while cs_n = 0 and rc_n = 0, arms sync. The next frame's first read edge then drives sync = 1 with data 0. The second read edge clears sync and drives the MSB, and the 17th read edge drives the LSB.
- R8: An external read made while busy is low returns the previous result. A read made after busy returns high returns the new result.
- R9: A conversion start and a busy rise each restart the external frame. The data line goes to 0, and the next read edge counts as the first.
- R10: With ext_mode = 1 the data clock output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rc_n | input | 1 | Read (1) / convert (0) control |
| ext_mode | input | 1 | 0 = internal data clock, 1 = external data clock |
| xclk | input | 1 | External data clock, sampled on clk |
| core_result | input | DATA_W | Parallel result from the converter core |
| busy | output | 1 | Low while a conversion is running |
| dclk_out | output | 1 | Data clock produced in internal mode |
| sdata | output | 1 | Serial data, MSB first |
| sync | output | 1 | Frame sync bit in external mode |

## Verification
The assertions assume that every input is synchronous to clk and that cs_n and rc_n are high while reset is applied. They also assume that ext_mode changes only while no internal frame is being shifted. The bench drives every input on the falling clock edge only. It changes the mode only after busy has returned high and the internal frame has finished. It also spaces xclk edges at least one system cycle apart, so every transition is seen by the sampling register.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic {
      CLK_INTERNAL = 1'b0,
      CLK_EXTERNAL = 1'b1
   } clk_src_e;

   localparam int unsigned MIN_DATA_W = 2;
endpackage

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CONV_CYCLES = 40,
   parameter logic [DATA_W-1:0] PWRUP_WORD = 16'hA5C3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rc_n,
   input  logic [DATA_W-1:0] core_result,
   output logic              busy,
   output logic              start,
   output logic              done,
   output logic [DATA_W-1:0] res_word
);
   localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1);

   logic             comb_q;
   logic [CNT_W-1:0] left;
   logic             comb_now;

   always_comb begin
      comb_now = cs_n | rc_n;
      start    = busy & comb_q & ~comb_now;
      done     = ~busy & (left == CNT_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         comb_q   <= 1'b1;
         busy     <= 1'b1;
         left     <= '0;
         res_word <= PWRUP_WORD;
      end else begin
         comb_q <= comb_now;
         if (start) begin
            busy <= 1'b0;
            left <= CNT_W'(CONV_CYCLES);
         end else if (!busy) begin
            left <= left - CNT_W'(1);
            if (done) begin
               busy     <= 1'b1;
               res_word <= core_result;
            end
         end
      end
   end
endmodule

// File: rtl/sar_int_ser.sv
module sar_int_ser #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              start,
   input  logic [DATA_W-1:0] word,
   output logic              dclk,
   output logic              sd
);
   localparam int unsigned POS_W = $clog2(DATA_W + 1);

   logic [POS_W-1:0] pos;
   logic             ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos  <= '0;
         ph   <= 1'b0;
         dclk <= 1'b0;
         sd   <= 1'b0;
      end else if (en && start) begin
         pos  <= POS_W'(1);
         ph   <= 1'b0;
         dclk <= 1'b0;
         sd   <= word[DATA_W-1];
      end else if (pos != '0) begin
         if (!ph) begin
            ph   <= 1'b1;
            dclk <= 1'b1;
         end else begin
            ph   <= 1'b0;
            dclk <= 1'b0;
            if (pos == POS_W'(DATA_W)) begin
               pos <= '0;
               sd  <= 1'b0;
            end else begin
               pos <= pos + POS_W'(1);
               sd  <= word[DATA_W-1-int'(pos)];
            end
         end
      end
   end
endmodule

// File: rtl/sar_ext_ser.sv
module sar_ext_ser #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cs_n,
   input  logic              rc_n,
   input  logic              xclk,
   input  logic              frame_rst,
   input  logic [DATA_W-1:0] word,
   output logic              sd,
   output logic              sy
);
   localparam int unsigned POS_W = $clog2(DATA_W + 2);
   localparam logic [POS_W-1:0] POS_END = POS_W'(DATA_W + 1);

   logic             xq, armed, fsync;
   logic [POS_W-1:0] pos;
   logic             rd_win, xedge, xrise, arm_hit;

   always_comb begin
      rd_win  = ~cs_n & rc_n;
      xedge   = xclk ^ xq;
      xrise   = xclk & ~xq;
      arm_hit = en & xedge & ~rd_win;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xq    <= 1'b0;
         armed <= 1'b0;
         fsync <= 1'b0;
         pos   <= '0;
         sd    <= 1'b0;
         sy    <= 1'b0;
      end else begin
         xq <= xclk;
         if (arm_hit) armed <= 1'b1;
         if (frame_rst) begin
            pos <= '0;
            sd  <= 1'b0;
            sy  <= 1'b0;
         end else if (en && xrise && rd_win) begin
            if (pos == '0) begin
               fsync <= armed;
               armed <= 1'b0;
               sy    <= armed;
               sd    <= armed ? 1'b0 : word[DATA_W-1];
               pos   <= POS_W'(1);
            end else begin
               sy <= 1'b0;
               if (fsync)
                  sd <= (pos <= POS_W'(DATA_W)) ? word[DATA_W-int'(pos)] : 1'b0;
               else
                  sd <= (pos < POS_W'(DATA_W)) ? word[DATA_W-1-int'(pos)] : 1'b0;
               if (pos != POS_END) pos <= pos + POS_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CONV_CYCLES = 40,
   parameter logic [DATA_W-1:0] PWRUP_WORD = 16'hA5C3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rc_n,
   input  logic              ext_mode,
   input  logic              xclk,
   input  logic [DATA_W-1:0] core_result,
   output logic              busy,
   output logic              dclk_out,
   output logic              sdata,
   output logic              sync
);
   import sar_pkg::*;

   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_width
         $error("DATA_W too small");
      end
      if (CONV_CYCLES < 2 * DATA_W + 2) begin : g_bad_conv
         $error("CONV_CYCLES too short for the internal frame");
      end
   endgenerate

   clk_src_e          src;
   logic              start, done;
   logic [DATA_W-1:0] res_word;
   logic              int_dclk, int_sd, ext_sd, ext_sy;

   assign src = clk_src_e'(ext_mode);

   sar_conv_timer #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES), .PWRUP_WORD(PWRUP_WORD)) u_timer (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n), .core_result(core_result),
      .busy(busy), .start(start), .done(done), .res_word(res_word));

   sar_int_ser #(.DATA_W(DATA_W)) u_int (
      .clk(clk), .rst_n(rst_n), .en(src == CLK_INTERNAL), .start(start),
      .word(res_word), .dclk(int_dclk), .sd(int_sd));

   sar_ext_ser #(.DATA_W(DATA_W)) u_ext (
      .clk(clk), .rst_n(rst_n), .en(src == CLK_EXTERNAL), .cs_n(cs_n), .rc_n(rc_n),
      .xclk(xclk), .frame_rst(start | done), .word(res_word), .sd(ext_sd), .sy(ext_sy));

   always_comb begin
      dclk_out = (src == CLK_INTERNAL) & int_dclk;
      sdata    = (src == CLK_EXTERNAL) ? ext_sd : int_sd;
      sync     = (src == CLK_EXTERNAL) & ext_sy;
   end
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CONV_CYCLES = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              rc_n,
   input logic              busy,
   input logic              dclk_out,
   input logic              sdata,
   input logic              sync,
   input logic [DATA_W-1:0] res_word
);
   int unsigned low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) low_cnt <= 0;
      else if (!busy) low_cnt <= (low_cnt < 32'hFFFF) ? low_cnt + 1 : low_cnt;
      else low_cnt <= 0;
   end

   assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> low_cnt == CONV_CYCLES);

   assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(cs_n | rc_n) == 1'b0);

   assert_res_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(busy) |-> $stable(res_word));

   assert_dclk_in_conv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dclk_out |-> !busy);

   assert_sync_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync |-> !sdata);
endmodule

bind sar_serial_port sar_serial_port_chk #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n), .busy(busy), .dclk_out(dclk_out),
   .sdata(sdata), .sync(sync), .res_word(res_word));

// File: tb/tb_sar_serial_port.sv
module tb_sar_serial_port;
   localparam int CONV = 40;
   localparam logic [15:0] PWR = 16'hA5C3;

   logic clk = 0, rst_n = 0, cs_n = 1, rc_n = 1, ext_mode = 0, xclk = 0;
   logic [15:0] core_result = 16'h0;
   logic busy, dclk_out, sdata, sync;
   int n_chk = 0, n_fail = 0, cyc = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   sar_serial_port dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n), .ext_mode(ext_mode),
      .xclk(xclk), .core_result(core_result), .busy(busy), .dclk_out(dclk_out),
      .sdata(sdata), .sync(sync));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference: timeline counters rather than a copy of the hardware
   logic m_busy, m_combq, m_xq, m_armed, m_fs;
   logic [15:0] m_res;
   int m_left, m_t, m_k;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 1; m_combq = 1; m_xq = 0; m_armed = 0; m_fs = 0;
         m_res = PWR; m_left = 0; m_t = 1000; m_k = 0;
      end else begin
         automatic bit comb = cs_n | rc_n;
         automatic bit rd = !cs_n && rc_n;
         automatic bit st = m_busy && m_combq && !comb;
         automatic bit br = !m_busy && m_left == 1;
         if (ext_mode && (xclk != m_xq) && !rd) m_armed = 1;
         if (st || br) m_k = 0;
         else if (ext_mode && xclk && !m_xq && rd) begin
            if (m_k == 0) begin m_fs = m_armed; m_armed = 0; end
            if (m_k < 20) m_k++;
         end
         if (st && !ext_mode) m_t = 0;
         else if (m_t < 1000) m_t++;
         if (st) begin m_busy = 0; m_left = CONV; end
         else if (!m_busy) begin
            m_left--;
            if (m_left == 0) begin m_busy = 1; m_res = core_result; end
         end
         m_combq = comb; m_xq = xclk;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         automatic bit e_dclk = !ext_mode && m_t < 32 && (m_t % 2 == 1);
         automatic bit e_sd, e_sy = 0;
         if (!ext_mode) e_sd = (m_t < 32) ? m_res[15 - m_t/2] : 1'b0;
         else if (m_k == 0) e_sd = 0;
         else if (m_fs) begin
            e_sy = (m_k == 1);
            e_sd = (m_k >= 2 && m_k <= 17) ? m_res[17 - m_k] : 1'b0;
         end else e_sd = (m_k <= 16) ? m_res[16 - m_k] : 1'b0;
         chk(busy === m_busy, "R2 busy vs model", busy, m_busy);
         chk(dclk_out === e_dclk, ext_mode ? "R10 dclk vs model" : "R5 dclk vs model", dclk_out, e_dclk);
         chk(sdata === e_sd, ext_mode ? "R6 sdata vs model" : "R5 sdata vs model", sdata, e_sd);
         chk(sync === e_sy, "R7 sync vs model", sync, e_sy);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic start_conv(input bit cs_last);
      if (cs_last) begin
         cs_n = 1;
         @(negedge clk) rc_n = 0;
         @(negedge clk) cs_n = 0;
      end else begin
         @(negedge clk) rc_n = 0;
      end
      @(negedge clk) rc_n = 1;
   endtask

   // counts busy-low negedges, collects internal frame bits
   task automatic run_int(input bit poke, output int len, output int pulses, output logic [15:0] w);
      logic prev = 0;
      len = 0; pulses = 0; w = 0;
      while (busy == 0) begin
         if (dclk_out && !prev) begin w = {w[14:0], sdata}; pulses++; end
         prev = dclk_out;
         len++;
         if (poke && len == 10) rc_n = 0;
         if (poke && len == 11) rc_n = 1;
         @(negedge clk);
      end
   endtask

   task automatic xpulse(output logic d, output logic s);
      @(negedge clk) xclk = 1;
      @(negedge clk) begin d = sdata; s = sync; xclk = 0; end
   endtask

   task automatic read_word(output logic [15:0] w);
      logic d, s;
      w = 0;
      for (int i = 0; i < 16; i++) begin xpulse(d, s); w = {w[14:0], d}; end
   endtask

   task automatic wait_idle();
      while (busy == 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      int len, pulses;
      logic [15:0] w;
      logic d, s;
      repeat (3) @(negedge clk);
      chk(busy === 1 && dclk_out === 0 && sdata === 0 && sync === 0, "R1 reset outputs",
          {busy, dclk_out, sdata, sync}, 4'b1000);
      rst_n = 1; cs_n = 0;
      repeat (2) @(negedge clk);
      chk(busy === 1, "R1 busy after reset", busy, 1);

      // internal mode
      core_result = 16'h1234;
      start_conv(0);
      run_int(0, len, pulses, w);
      chk(len == CONV, "R2 busy low length", len, CONV);
      chk(w == PWR, "R4 power-up word emitted", w, PWR);
      chk(pulses == 16, "R5 pulse count", pulses, 16);
      chk(dclk_out === 0 && sdata === 0, "R5 idle after frame", {dclk_out, sdata}, 0);

      core_result = 16'hBEEF;
      @(negedge clk);
      start_conv(1);
      run_int(1, len, pulses, w);
      chk(len == CONV, "R3 restart ignored, length", len, CONV);
      chk(w == 16'h1234, "R2 cs-last start, previous word", w, 16'h1234);
      repeat (3) @(negedge clk);
      chk(busy === 1, "R3 no extra conversion", busy, 1);

      core_result = 16'h0001;
      start_conv(0);
      run_int(0, len, pulses, w);
      chk(w == 16'hBEEF, "R5 previous result", w, 16'hBEEF);
      repeat (2) @(negedge clk);

      // external mode
      ext_mode = 1;
      core_result = 16'h5A0F;
      start_conv(0);
      wait_idle();
      read_word(w);
      chk(w == 16'h5A0F, "R8 read after conversion", w, 16'h5A0F);
      xpulse(d, s);
      chk(d === 0 && s === 0, "R6 data 0 after 16 bits", {d, s}, 0);
      chk(dclk_out === 0, "R10 no dclk in ext mode", dclk_out, 0);

      core_result = 16'hC3E1;
      start_conv(0);
      read_word(w);
      chk(w == 16'h5A0F, "R8 read during conversion", w, 16'h5A0F);
      wait_idle();

      cs_n = 1;
      @(negedge clk) xclk = 1;
      @(negedge clk) xclk = 0;
      @(negedge clk) cs_n = 0;
      xpulse(d, s);
      chk(s === 1 && d === 0, "R7 sync bit (cs high arm)", {s, d}, 2'b10);
      read_word(w);
      chk(w == 16'hC3E1, "R7 word after sync", w, 16'hC3E1);

      core_result = 16'h0F96;
      @(negedge clk) rc_n = 0;
      @(negedge clk) xclk = 1;
      @(negedge clk) begin xclk = 0; rc_n = 1; end
      xpulse(d, s);
      chk(s === 1 && d === 0, "R7 sync bit (both low arm)", {s, d}, 2'b10);
      read_word(w);
      chk(w == 16'hC3E1, "R7 sync frame previous word", w, 16'hC3E1);
      wait_idle();

      for (int i = 0; i < 4; i++) xpulse(d, s);
      core_result = 16'h1111;
      start_conv(0);
      chk(sdata === 0, "R9 data cleared at start", sdata, 0);
      read_word(w);
      chk(w == 16'h0F96, "R9 frame restarted at MSB", w, 16'h0F96);
      wait_idle();

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule